// File: doc/BRIEF.md
# Two-Channel Output Latch Access Handler

This block is the function layer of a single-wire slave that owns two open-drain output channels. Once the addressing layer has selected the device it pulses `func_go`. The handler then takes one function byte from the bit engine and serves one of two commands. The status command streams status bytes until a bus reset ends it. The write command takes a data byte and then its bitwise inverse. It updates the two output latches only when the pair agrees, answers with a fixed confirmation byte and a fresh status byte, and waits for the next pair.

Bytes move over two valid/ready streams shared with the bit engine. On the receive stream the engine holds `rx_valid` and `rx_data` until it sees `rx_ready`. On the transmit stream the handler holds `tx_valid` and `tx_data` unchanged until it sees `tx_ready`. A byte moves on a clock edge where valid and ready are both high and `bus_reset` is low. Either side may stall for any number of cycles. `bus_reset` is a plain control pulse. It sends the handler back to its idle state and discards any handshake in the same cycle. The output latches keep their values across a bus reset.

Pin inputs pass through a synchronizer of `SYNC_STAGES` flops. A pin must be settled at least that many cycles before the transmit handshake that samples it.

Top module: `pio_access_handler`

## Requirements
- R1: After `rst_n` both latches hold 1, so `pd_a` and `pd_b` are 0, and `rx_ready` and `tx_valid` are 0.
- R2: A function byte other than F5h (status) or 5Ah (write) leaves `rx_ready` and `tx_valid` low until a bus reset followed by `func_go`.
- R3: A status byte holds pin A in bit 0, latch A in bit 1, pin B in bit 2 and latch B in bit 3. Bits 7..4 are the bitwise complement of bits 3..0.
- R4: Both pins are sampled together when the preceding byte is handed over. That byte is the F5h function byte, the previous status byte, or the AAh confirmation. The status command repeats status bytes without end.
- R5: In the write command, bit 0 of the data byte sets latch A and bit 1 sets latch B. Pulldown enable = NOT latch, so a 0 bit turns the pulldown on. The latches change on the cycle after the inverted byte is accepted, and only if that byte equals the bitwise NOT of the data byte.
- R6: After a matching pair the handler sends AAh, then one status byte, then accepts the next data byte.
- R7: After a mismatching pair both latches are unchanged, `rx_ready` stays low, and every transmitted byte is FFh until a bus reset.
- R8: `bus_reset` wins over a handshake in the same cycle. That byte is dropped, the latches keep their values, and on the next cycle `rx_ready` and `tx_valid` are both low.
- R9: `tx_data` and `tx_valid` hold steady while `tx_ready` is low. `rx_ready` and `tx_valid` are never high together.
- R10: Before `func_go`, and after a bus reset, the handler raises neither `rx_ready` nor `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets both latches to 1 |
| bus_reset | input | 1 | Bus reset pulse from the bit engine; ends any command |
| func_go | input | 1 | Pulse from the addressing layer: accept a function byte |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Handler accepts a received byte |
| rx_data | input | 8 | Received byte, least significant bit first on the wire |
| tx_valid | output | 1 | Byte to transmit available |
| tx_ready | input | 1 | Bit engine takes the byte |
| tx_data | output | 8 | Byte to transmit |
| pin_a | input | 1 | Sensed level of channel A |
| pin_b | input | 1 | Sensed level of channel B |
| pd_a | output | 1 | Pulldown enable of channel A |
| pd_b | output | 1 | Pulldown enable of channel B |

## Verification
A bus reset can land on the same edge as the acceptance of the inverted write byte. In that case a latch update and a command abort meet in one cycle. The bench provokes this by raising `bus_reset` together with `rx_valid` while the handler waits for the inverted byte. It judges the result at the ports. The pulldown outputs must not move, both stream controls must be low, and a later status command must report the old latch values. A second overlap is a pin change just before a status handshake. It is judged by sweeping the pin levels and expecting each byte to show the levels present at the previous byte's handover.

// File: rtl/pio_acc_pkg.sv
package pio_acc_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;
  localparam logic [BYTE_W-1:0] FN_STATUS = 8'hF5;
  localparam logic [BYTE_W-1:0] FN_WRITE  = 8'h5A;
  localparam logic [BYTE_W-1:0] CONFIRM   = 8'hAA;
  localparam logic [BYTE_W-1:0] FILL      = 8'hFF;

  typedef enum logic [2:0] {
    ST_OFF, ST_FUNC, ST_DATA, ST_INV, ST_CONF, ST_STAT, ST_FILL, ST_HALT
  } acc_state_t;
endpackage

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_sync
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
          pipe[0] <= d;
          for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pio_latch_bank.sv
module pio_latch_bank #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic [NCH-1:0] new_val,
  output logic [NCH-1:0] lat
);
  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   lat[g] <= 1'b1;
        else if (upd) lat[g] <= new_val[g];
      end
    end
  endgenerate

  // R5
  latch_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(lat));
endmodule

// File: rtl/pio_status_cap.sv
module pio_status_cap
  import pio_acc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [NCH-1:0]    pins,
  input  logic [NCH-1:0]    lat,
  output logic [BYTE_W-1:0] status
);
  localparam int LOW_W = 2 * NCH;

  logic [LOW_W-1:0] low;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_pack
      assign low[2*g]   = pins[g];
      assign low[2*g+1] = lat[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= {~{LOW_W{1'b0}}, {LOW_W{1'b0}}};
    else if (cap) status <= {~low, low};
  end
endmodule

// File: rtl/pio_acc_fsm.sv
module pio_acc_fsm
  import pio_acc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              func_go,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic [BYTE_W-1:0] status,
  output logic              cap,
  output logic              upd,
  output logic [NCH-1:0]    new_val
);
  acc_state_t state, state_n;
  logic [BYTE_W-1:0] data_q;
  logic mode_rd;
  logic rx_hs, tx_hs, pair_ok;

  assign rx_ready = (state == ST_FUNC) || (state == ST_DATA) || (state == ST_INV);
  assign tx_valid = (state == ST_CONF) || (state == ST_STAT) || (state == ST_FILL);
  assign rx_hs    = rx_valid && rx_ready && !bus_reset;
  assign tx_hs    = tx_valid && tx_ready && !bus_reset;
  assign pair_ok  = (rx_data == ~data_q);
  assign upd      = (state == ST_INV) && rx_hs && pair_ok;
  assign new_val  = data_q[NCH-1:0];

  always_comb begin
    case (state)
      ST_CONF: tx_data = CONFIRM;
      ST_FILL: tx_data = FILL;
      default: tx_data = status;
    endcase
  end

  always_comb begin
    cap = 1'b0;
    if (state == ST_FUNC && rx_hs && rx_data == FN_STATUS) cap = 1'b1;
    if (tx_hs && state == ST_CONF)                         cap = 1'b1;
    if (tx_hs && state == ST_STAT && mode_rd)              cap = 1'b1;
  end

  always_comb begin
    state_n = state;
    case (state)
      ST_OFF:  if (func_go) state_n = ST_FUNC;
      ST_FUNC: if (rx_hs) begin
                 if (rx_data == FN_STATUS)     state_n = ST_STAT;
                 else if (rx_data == FN_WRITE) state_n = ST_DATA;
                 else                          state_n = ST_HALT;
               end
      ST_DATA: if (rx_hs) state_n = ST_INV;
      ST_INV:  if (rx_hs) state_n = pair_ok ? ST_CONF : ST_FILL;
      ST_CONF: if (tx_hs) state_n = ST_STAT;
      ST_STAT: if (tx_hs) state_n = mode_rd ? ST_STAT : ST_DATA;
      default: state_n = state;
    endcase
    if (bus_reset) state_n = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      data_q  <= '1;
      mode_rd <= 1'b0;
    end else begin
      state <= state_n;
      if (state == ST_DATA && rx_hs) data_q <= rx_data;
      if (state == ST_FUNC && rx_hs) mode_rd <= (rx_data == FN_STATUS);
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_reset) |=> (tx_valid && $stable(tx_data)));
  // R9
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));
  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!rx_ready && !tx_valid));
  // R2
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !bus_reset) |=> (!rx_ready && !tx_valid));
endmodule

// File: rtl/pio_access_handler.sv
module pio_access_handler
  import pio_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              func_go,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              pin_a,
  input  logic              pin_b,
  output logic              pd_a,
  output logic              pd_b
);
  logic [NCH-1:0]    pins_s, lat, new_val;
  logic [BYTE_W-1:0] status;
  logic              cap, upd;

  pio_pin_sync #(.STAGES(SYNC_STAGES), .W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pin_b, pin_a}), .q(pins_s));

  pio_latch_bank #(.NCH(NCH)) u_lat (
    .clk(clk), .rst_n(rst_n), .upd(upd), .new_val(new_val), .lat(lat));

  pio_status_cap #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .cap(cap), .pins(pins_s), .lat(lat),
    .status(status));

  pio_acc_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .func_go(func_go),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .status(status), .cap(cap), .upd(upd), .new_val(new_val));

  assign pd_a = ~lat[0];
  assign pd_b = ~lat[1];
endmodule

// File: tb/pio_access_handler_test.sv
module pio_access_handler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0, func_go = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, pd_a, pd_b;
  logic [7:0] tx_data;
  logic ext_a = 1'b1, ext_b = 1'b1;
  logic pin_a, pin_b;
  int checks = 0, failures = 0;
  logic la_e = 1'b1, lb_e = 1'b1;

  always #4 clk = ~clk;

  assign pin_a = ext_a & ~pd_a;
  assign pin_b = ext_b & ~pd_b;

  pio_access_handler uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .func_go(func_go),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .pin_a(pin_a), .pin_b(pin_b), .pd_a(pd_a), .pd_b(pd_b));

  function automatic logic [7:0] stat_of(logic pa, logic la, logic pb, logic lb);
    logic [3:0] lo;
    lo = {lb, pb, la, pa};
    return {~lo, lo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    for (int i = 0; i < 100 && !rx_ready; i++) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    logic [7:0] first;
    b = 8'h00;
    @(negedge clk);
    for (int i = 0; i < 100 && !tx_valid; i++) @(negedge clk);
    first = tx_data;
    repeat (4) @(negedge clk);
    // R9: byte held while stalled
    chk(tx_valid && tx_data == first, "R9 hold", {tx_valid, tx_data}, {1'b1, first});
    b = tx_data; tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic pulse_reset_go();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    // R10
    chk(!rx_ready && !tx_valid, "R10 idle", {rx_ready, tx_valid}, 0);
    func_go = 1'b1;
    @(negedge clk); func_go = 1'b0;
  endtask

  task automatic write_pair(input logic [1:0] d, input logic [7:0] sexp_unused);
    logic [7:0] b, dat;
    dat = {6'b111111, d};
    send(dat);
    // R5: no change before inverted byte
    chk({pd_b, pd_a} == {~lb_e, ~la_e}, "R5 early", {pd_b, pd_a}, {~lb_e, ~la_e});
    send(~dat);
    la_e = d[0]; lb_e = d[1];
    chk({pd_b, pd_a} == {~lb_e, ~la_e}, "R5 latch", {pd_b, pd_a}, {~lb_e, ~la_e});
    recv(b);
    chk(b == 8'hAA, "R6 confirm", b, 8'hAA);
    recv(b);
    chk(b == stat_of(ext_a & la_e, la_e, ext_b & lb_e, lb_e), "R6 status", b,
        stat_of(ext_a & la_e, la_e, ext_b & lb_e, lb_e));
    if (sexp_unused != 8'h00) chk(b == sexp_unused, "R6 example", b, sexp_unused);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b, expv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(pd_a == 0 && pd_b == 0, "R1 latches", {pd_b, pd_a}, 0);
    chk(!rx_ready && !tx_valid, "R1 streams", {rx_ready, tx_valid}, 0);
    repeat (5) @(negedge clk);
    // R10
    chk(!rx_ready && !tx_valid, "R10 before go", {rx_ready, tx_valid}, 0);

    // R3 R4: status sweep over pin levels
    ext_a = 1'b0; ext_b = 1'b0;
    repeat (3) @(negedge clk);
    func_go = 1'b1; @(negedge clk); func_go = 1'b0;
    send(8'hF5);
    expv = stat_of(1'b0, 1'b1, 1'b0, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      ext_a = k[0]; ext_b = k[1];
      repeat (3) @(negedge clk);
      recv(b);
      chk(b == expv, "R4 sample", b, expv);
      chk(b[7:4] == ~b[3:0], "R3 complement", b, {~b[3:0], b[3:0]});
      expv = stat_of(ext_a, 1'b1, ext_b, 1'b1);
    end

    // R5 R6: write sweep
    ext_a = 1'b1; ext_b = 1'b1;
    pulse_reset_go();
    send(8'h5A);
    for (int d = 0; d < 4; d++) write_pair(d[1:0], 8'h00);
    write_pair(2'b00, 8'hF0);
    write_pair(2'b01, 8'hC3);

    // R7: mismatch
    send(8'hFE);
    send(8'h00);
    chk({pd_b, pd_a} == {~lb_e, ~la_e}, "R7 latches", {pd_b, pd_a}, {~lb_e, ~la_e});
    for (int k = 0; k < 3; k++) begin
      recv(b);
      chk(b == 8'hFF, "R7 fill", b, 8'hFF);
    end
    chk(!rx_ready, "R7 no rx", rx_ready, 0);

    // R2: unknown function byte
    pulse_reset_go();
    send(8'h33);
    repeat (10) @(negedge clk);
    chk(!rx_ready && !tx_valid, "R2 halt", {rx_ready, tx_valid}, 0);

    // R8: bus reset on the inverted byte handshake
    pulse_reset_go();
    send(8'h5A);
    send(8'hFC);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h03; bus_reset = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_reset = 1'b0;
    chk({pd_b, pd_a} == {~lb_e, ~la_e}, "R8 latches", {pd_b, pd_a}, {~lb_e, ~la_e});
    chk(!rx_ready && !tx_valid, "R8 idle", {rx_ready, tx_valid}, 0);
    func_go = 1'b1; @(negedge clk); func_go = 1'b0;
    send(8'hF5);
    recv(b);
    expv = stat_of(ext_a & la_e, la_e, ext_b & lb_e, lb_e);
    chk(b == expv, "R8 kept", b, expv);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule